// File: doc/BRIEF.md
# Dual-Path Predication Mode Controller

This block sits in the fetch front end and decides when the machine should stop trusting the branch predictor on a single path and instead fetch both sides of a hard-to-predict branch. It watches branches as they are decoded. A branch is a candidate when the instruction marks it as a diverge branch and the confidence estimator flags it as weak. For a candidate, the controller computes the address where the two paths join again and keeps that address in a register. It also takes a predicate tag from a free pool of 32 and sends one-cycle fork strobes to the return stack, the global history register and the rename table.

While the mode is active, the controller picks which path owns each fetch slot, alternating between the two. A path that reaches the join address stops fetching, and the other path then takes every slot. The mode ends for one of four reasons: both paths have reached the join point, the diverge branch resolves, too many instructions have been fetched in the mode, or a newer weak diverge branch shows up on the predicted path while the yield policy is selected. In that last case the controller leaves the mode and enters it again at the newer branch on the same clock edge. A pipeline flush returns the controller to idle and gives back the tag it was holding. Tags for completed modes come back through a separate retire port.

The decoded-branch, fetch, resolve and retire inputs are single-cycle qualified strobes with no ready signal. The controller accepts one of each every cycle and never applies back-pressure, so a source may drive a new item on every cycle. All outputs are registered and change one clock edge after the input that causes them.

Top module: `dpred_mode_ctrl`

## Requirements
- R1: The mode is entered only when `dec_valid` is high, `dec_type` is 2'b10 (forward diverge) or 2'b11 (loop diverge), `dec_lowconf` is high and a tag is free. One edge later `mode_active` is 1 and `fork_ras`, `fork_ghr` and `fork_rat` are high for exactly that one cycle. A type of 2'b00 or 2'b01, or a high-confidence branch, does not enter the mode.
- R2: On entry `merge_pc` takes the value `dec_pc` plus `dec_off`, where `dec_off` is sign-extended two's complement. The value holds for as long as the mode lasts.
- R3: `pred_id` is the lowest-numbered free tag out of 32. A tag stays taken until `ret_valid` returns it on `ret_id`. When no tag is free, a candidate branch does not enter the mode.
- R4: While the mode is active, `sel_path` (0 = predicted path, 1 = alternate path) starts at 0 on entry and toggles after every `fet_valid`. It is 0 whenever the mode is inactive.
- R5: A fetch on the selected path with `fet_pc` equal to `merge_pc` marks that path finished. From then on `sel_path` stays on the other path. When both paths are finished the mode exits with `exit_cause` 3'd1.
- R6: `resolve_valid` during the mode ends it with `exit_cause` 3'd2. This takes priority over every other exit reason in the same cycle.
- R7: Each `fet_valid` in the mode is counted. The fetch that makes the count exceed `fetch_limit` ends the mode with `exit_cause` 3'd3.
- R8: With `policy_yield` at 1, a candidate branch decoded on path 0 (`dec_path` = 0) during the mode ends it with `exit_cause` 3'd4 and re-enters at once with a new merge address and a new tag. With `policy_yield` at 0, or on path 1, such a branch is ignored.
- R9: `flush` makes the controller idle one edge later, with no exit pulse, and returns the tag it held to the pool.
- R10: After reset the mode is inactive, `sel_path` is 0, all strobes are low and all 32 tags are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| policy_yield | input | 1 | 1 selects the yield rule for nested candidates |
| fetch_limit | input | CW | Fetch-count threshold for the mode |
| dec_valid | input | 1 | Decoded branch strobe |
| dec_type | input | 2 | Branch kind field |
| dec_pc | input | AW | Branch address |
| dec_off | input | OW | Signed offset to the join address |
| dec_lowconf | input | 1 | Confidence estimator marks branch weak |
| dec_path | input | 1 | Path the decoded branch belongs to |
| fet_valid | input | 1 | One instruction fetched on the selected path |
| fet_pc | input | AW | Address of that instruction |
| resolve_valid | input | 1 | The diverge branch has resolved |
| flush | input | 1 | Pipeline flush |
| ret_valid | input | 1 | Return a tag to the pool |
| ret_id | input | IW | Tag being returned |
| mode_active | output | 1 | Dual-path mode in progress |
| sel_path | output | 1 | Path that owns the next fetch slot |
| merge_pc | output | AW | Stored join address |
| pred_id | output | IW | Tag of the current mode |
| fork_ras | output | 1 | Fork strobe for the return stack |
| fork_ghr | output | 1 | Fork strobe for the global history |
| fork_rat | output | 1 | Fork strobe for the rename table |
| exit_pulse | output | 1 | One-cycle strobe when the mode ends |
| exit_cause | output | 3 | Exit reason, valid with `exit_pulse` |

## Verification
The bench targets the path hand-over after one side reaches the join address. A design that kept toggling there would hand slots to a finished path and never reach the both-done exit. It fires resolve in the same cycle as a fetch that would complete both paths, which catches a design with the exit priority reversed. It runs the fetch count to exactly the limit and then one fetch past it, which exposes an off-by-one in the threshold compare. It sends nested candidates under both policies and on both paths: a design that yields too eagerly would replace the join address, and one that fails to re-enter would drop to idle. It also drains all 32 tags and then returns one in the middle of the pool. It checks that a flushed tag is the next one handed out, so a design that loses tags or ignores the empty pool is caught.

// File: rtl/dpred_pkg.sv
package dpred_pkg;

  localparam logic [1:0] BT_FWD_DIV  = 2'b10;
  localparam logic [1:0] BT_LOOP_DIV = 2'b11;

  typedef enum logic [2:0] {
    XC_NONE    = 3'd0,
    XC_MERGE   = 3'd1,
    XC_RESOLVE = 3'd2,
    XC_COUNT   = 3'd3,
    XC_YIELD   = 3'd4
  } exit_cause_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } mode_state_e;

endpackage

// File: rtl/dpred_id_pool.sv
module dpred_id_pool #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic          rel_a_v,
  input  logic [IW-1:0] rel_a_id,
  input  logic          rel_b_v,
  input  logic [IW-1:0] rel_b_id,
  output logic          any_free,
  output logic [IW-1:0] alloc_id
);

  logic [N-1:0] free_q;
  logic [N-1:0] free_d;
  logic         found;

  // lowest free tag wins
  always_comb begin
    alloc_id = '0;
    found    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (free_q[i] && !found) begin
        alloc_id = IW'(i);
        found    = 1'b1;
      end
    end
    any_free = found;
  end

  always_comb begin
    free_d = free_q;
    if (rel_a_v) free_d[rel_a_id] = 1'b1;
    if (rel_b_v) free_d[rel_b_id] = 1'b1;
    if (alloc_req && found) free_d[alloc_id] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= free_d;
  end

endmodule

// File: rtl/dpred_path_rr.sv
module dpred_path_rr (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic fire,
  input  logic hit,
  output logic sel,
  output logic all_done
);

  logic [1:0] done_q;
  logic [1:0] done_d;
  logic       sel_q;

  always_comb begin
    done_d = done_q;
    if (fire && hit) done_d[sel_q] = 1'b1;
    all_done = fire && (&done_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      sel_q  <= 1'b0;
    end else if (restart) begin
      done_q <= '0;
      sel_q  <= 1'b0;
    end else if (fire) begin
      done_q <= done_d;
      // hand the slot over unless the other side has already arrived
      if (!done_d[~sel_q]) sel_q <= ~sel_q;
    end
  end

  assign sel = sel_q;

endmodule

// File: rtl/dpred_fetch_cnt.sv
module dpred_fetch_cnt #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          over
);

  localparam int XW = CW + 1;

  logic [XW-1:0] cnt_q;
  logic [XW-1:0] cnt_nx;

  assign cnt_nx = cnt_q + XW'(1);
  assign over   = inc && (cnt_nx > {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (clr)                       cnt_q <= '0;
    else if (inc && (cnt_q != '1))      cnt_q <= cnt_nx;
  end

endmodule

// File: rtl/dpred_mode_ctrl.sv
module dpred_mode_ctrl #(
  parameter int AW    = 32,
  parameter int OW    = 12,
  parameter int CW    = 10,
  parameter int NPRED = 32,
  localparam int IW   = $clog2(NPRED)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          policy_yield,
  input  logic [CW-1:0] fetch_limit,
  input  logic          dec_valid,
  input  logic [1:0]    dec_type,
  input  logic [AW-1:0] dec_pc,
  input  logic [OW-1:0] dec_off,
  input  logic          dec_lowconf,
  input  logic          dec_path,
  input  logic          fet_valid,
  input  logic [AW-1:0] fet_pc,
  input  logic          resolve_valid,
  input  logic          flush,
  input  logic          ret_valid,
  input  logic [IW-1:0] ret_id,
  output logic          mode_active,
  output logic          sel_path,
  output logic [AW-1:0] merge_pc,
  output logic [IW-1:0] pred_id,
  output logic          fork_ras,
  output logic          fork_ghr,
  output logic          fork_rat,
  output logic          exit_pulse,
  output logic [2:0]    exit_cause
);
  import dpred_pkg::*;

  localparam int SXW = AW - OW;

  mode_state_e st_q, st_d;
  exit_cause_e cause_d;
  logic [AW-1:0] merge_q, tgt;
  logic [IW-1:0] id_q, alloc_id;
  logic          fork_q, xp_q;
  logic [2:0]    xc_q;
  logic          active, is_cand, enter_req, alloc_go, any_free;
  logic          fire, hit, all_done, over, restart;

  assign active  = (st_q == ST_ACTIVE);
  assign is_cand = dec_valid && dec_lowconf &&
                   ((dec_type == BT_FWD_DIV) || (dec_type == BT_LOOP_DIV));
  assign tgt     = dec_pc + {{SXW{dec_off[OW-1]}}, dec_off};
  assign fire    = active && fet_valid;
  assign hit     = (fet_pc == merge_q);

  // exit reason, highest priority first
  always_comb begin
    cause_d = XC_NONE;
    if (active && !flush) begin
      if (resolve_valid)                               cause_d = XC_RESOLVE;
      else if (all_done)                               cause_d = XC_MERGE;
      else if (over)                                   cause_d = XC_COUNT;
      else if (policy_yield && is_cand && !dec_path)   cause_d = XC_YIELD;
    end
  end

  assign enter_req = !flush && is_cand && (!active || (cause_d == XC_YIELD));
  assign alloc_go  = enter_req && any_free;

  always_comb begin
    st_d = st_q;
    if (flush)                    st_d = ST_IDLE;
    else if (alloc_go)            st_d = ST_ACTIVE;
    else if (cause_d != XC_NONE)  st_d = ST_IDLE;
  end

  assign restart = alloc_go || (st_d == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      merge_q <= '0;
      id_q    <= '0;
      fork_q  <= 1'b0;
      xp_q    <= 1'b0;
      xc_q    <= 3'd0;
    end else begin
      st_q   <= st_d;
      fork_q <= alloc_go;
      xp_q   <= (cause_d != XC_NONE);
      xc_q   <= cause_d;
      if (alloc_go) begin
        merge_q <= tgt;
        id_q    <= alloc_id;
      end
    end
  end

  dpred_id_pool #(.N(NPRED), .IW(IW)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_req(alloc_go),
    .rel_a_v  (ret_valid),
    .rel_a_id (ret_id),
    .rel_b_v  (flush && active),
    .rel_b_id (id_q),
    .any_free (any_free),
    .alloc_id (alloc_id)
  );

  dpred_path_rr u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .fire    (fire),
    .hit     (hit),
    .sel     (sel_path),
    .all_done(all_done)
  );

  dpred_fetch_cnt #(.CW(CW)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (restart),
    .inc  (fire),
    .limit(fetch_limit),
    .over (over)
  );

  assign mode_active = active;
  assign merge_pc    = merge_q;
  assign pred_id     = id_q;
  assign fork_ras    = fork_q;
  assign fork_ghr    = fork_q;
  assign fork_rat    = fork_q;
  assign exit_pulse  = xp_q;
  assign exit_cause  = xc_q;

endmodule

// File: rtl/dpred_mode_chk.sv
module dpred_mode_chk #(
  parameter int AW = 32,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          mode_active,
  input logic          sel_path,
  input logic [AW-1:0] merge_pc,
  input logic [IW-1:0] pred_id,
  input logic          fork_rat,
  input logic          exit_pulse,
  input logic [2:0]    exit_cause
);

  AST_ENTRY_FORKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_active) |-> fork_rat); // R1

  AST_FORK_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    fork_rat |-> mode_active); // R1

  AST_MERGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_active && $past(mode_active) && !fork_rat) |-> ($stable(merge_pc) && $stable(pred_id))); // R2

  AST_IDLE_PATH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_active |-> (sel_path == 1'b0)); // R4

  AST_EXIT_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_pulse && (exit_cause != 3'd4)) |-> !mode_active); // R5

  AST_EXIT_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |-> $past(mode_active)); // R6

  AST_FLUSH_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!mode_active && !exit_pulse)); // R9

endmodule

bind dpred_mode_ctrl dpred_mode_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .mode_active(mode_active),
  .sel_path   (sel_path),
  .merge_pc   (merge_pc),
  .pred_id    (pred_id),
  .fork_rat   (fork_rat),
  .exit_pulse (exit_pulse),
  .exit_cause (exit_cause)
);

// File: tb/dpred_mode_ctrl_tb.sv
`timescale 1ns/1ps
module dpred_mode_ctrl_tb;

  localparam int AW = 32, OW = 12, CW = 10, IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic policy_yield = 1'b0;
  logic [CW-1:0] fetch_limit = 10'd100;
  logic dec_valid = 1'b0, dec_lowconf = 1'b0, dec_path = 1'b0;
  logic [1:0] dec_type = 2'b00;
  logic [AW-1:0] dec_pc = '0, fet_pc = '0;
  logic [OW-1:0] dec_off = '0;
  logic fet_valid = 1'b0, resolve_valid = 1'b0, flush = 1'b0, ret_valid = 1'b0;
  logic [IW-1:0] ret_id = '0;
  logic mode_active, sel_path, fork_ras, fork_ghr, fork_rat, exit_pulse;
  logic [AW-1:0] merge_pc;
  logic [IW-1:0] pred_id;
  logic [2:0] exit_cause;

  always #2.5 clk = ~clk;

  dpred_mode_ctrl u_dut (.*);

  typedef struct packed {
    logic          is_entry;
    logic [2:0]    cause;
    logic [AW-1:0] pc;
    logic [IW-1:0] id;
  } exp_t;

  exp_t q[$];
  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void push_entry(input logic [AW-1:0] pc, input logic [IW-1:0] id);
    exp_t e;
    e = '{is_entry: 1'b1, cause: 3'd0, pc: pc, id: id};
    q.push_back(e);
  endfunction

  function automatic void push_exit(input logic [2:0] c);
    exp_t e;
    e = '{is_entry: 1'b0, cause: c, pc: '0, id: '0};
    q.push_back(e);
  endfunction

  // monitor: pop one expected item per observed event
  initial forever begin
    @(posedge clk); #1;
    if (rst_n) begin
      if (exit_pulse) begin
        if (q.size() == 0) chk(1'b0, "R5 R6 R7 R8 unexpected exit", 64'(exit_cause), 64'd0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(!e.is_entry && (exit_cause == e.cause), "exit cause R5 R6 R7 R8",
              64'(exit_cause), 64'(e.cause));
        end
      end
      if (fork_rat) begin
        if (q.size() == 0) chk(1'b0, "R1 unexpected entry", 64'(merge_pc), 64'd0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.is_entry && fork_ras && fork_ghr, "R1 fork strobes", 64'(fork_ras), 64'd1);
          chk(merge_pc == e.pc, "R2 merge address", 64'(merge_pc), 64'(e.pc));
          chk(pred_id == e.id, "R3 tag", 64'(pred_id), 64'(e.id));
        end
      end
    end
  end

  task automatic dec_br(input logic [1:0] t, input logic [AW-1:0] pc, input logic [OW-1:0] off,
                        input logic lc, input logic pth);
    @(negedge clk);
    dec_valid = 1'b1; dec_type = t; dec_pc = pc; dec_off = off; dec_lowconf = lc; dec_path = pth;
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  task automatic fetch(input logic [AW-1:0] pc, input logic res);
    @(negedge clk);
    fet_valid = 1'b1; fet_pc = pc; resolve_valid = res;
    @(negedge clk);
    fet_valid = 1'b0; resolve_valid = 1'b0;
  endtask

  task automatic resolve();
    @(negedge clk); resolve_valid = 1'b1;
    @(negedge clk); resolve_valid = 1'b0;
  endtask

  task automatic retire(input logic [IW-1:0] id);
    @(negedge clk); ret_valid = 1'b1; ret_id = id;
    @(negedge clk); ret_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!mode_active && !sel_path && !fork_rat && !fork_ras && !fork_ghr && !exit_pulse,
        "R10 reset outputs", 64'(mode_active), 64'd0);
    rst_n = 1'b1;

    // R1: non-candidates
    dec_br(2'b00, 32'h80, 12'h10, 1'b1, 1'b0);
    chk(!mode_active, "R1 normal branch", 64'(mode_active), 64'd0);
    dec_br(2'b01, 32'h80, 12'h10, 1'b1, 1'b0);
    chk(!mode_active, "R1 reserved type", 64'(mode_active), 64'd0);
    dec_br(2'b10, 32'h80, 12'h10, 1'b0, 1'b0);
    chk(!mode_active, "R1 high confidence", 64'(mode_active), 64'd0);

    // R1 R2 R4 R5: both paths reach the join point
    push_entry(32'h140, 5'd0);
    dec_br(2'b10, 32'h100, 12'h040, 1'b1, 1'b0);
    chk(mode_active, "R1 entered", 64'(mode_active), 64'd1);
    chk(sel_path == 1'b0, "R4 starts on path 0", 64'(sel_path), 64'd0);
    fetch(32'h104, 1'b0);
    chk(sel_path == 1'b1, "R4 toggles to 1", 64'(sel_path), 64'd1);
    fetch(32'h200, 1'b0);
    chk(sel_path == 1'b0, "R4 toggles to 0", 64'(sel_path), 64'd0);
    fetch(32'h140, 1'b0);
    chk(sel_path == 1'b1 && mode_active, "R5 path 0 done", 64'(sel_path), 64'd1);
    fetch(32'h204, 1'b0);
    chk(sel_path == 1'b1, "R5 path 1 keeps slots", 64'(sel_path), 64'd1);
    push_exit(3'd1);
    fetch(32'h140, 1'b0);
    chk(!mode_active, "R5 merge exit", 64'(mode_active), 64'd0);
    retire(5'd0);

    // R2 negative offset, R6 priority over merge
    push_entry(32'h3E0, 5'd0);
    dec_br(2'b11, 32'h400, 12'hFE0, 1'b1, 1'b0);
    fetch(32'h404, 1'b0);
    fetch(32'h3E0, 1'b0);
    chk(sel_path == 1'b0 && mode_active, "R5 path 1 done first", 64'(sel_path), 64'd0);
    push_exit(3'd2);
    fetch(32'h3E0, 1'b1);
    chk(!mode_active, "R6 resolve exit", 64'(mode_active), 64'd0);
    retire(5'd0);

    // R7 count threshold
    fetch_limit = 10'd3;
    push_entry(32'h520, 5'd0);
    dec_br(2'b10, 32'h500, 12'h020, 1'b1, 1'b0);
    fetch(32'h504, 1'b0);
    fetch(32'h600, 1'b0);
    fetch(32'h508, 1'b0);
    chk(mode_active, "R7 at limit still active", 64'(mode_active), 64'd1);
    push_exit(3'd3);
    fetch(32'h604, 1'b0);
    chk(!mode_active, "R7 over limit exit", 64'(mode_active), 64'd0);
    retire(5'd0);
    fetch_limit = 10'd100;

    // R8 nested candidates, R9 flush
    policy_yield = 1'b0;
    push_entry(32'h710, 5'd0);
    dec_br(2'b10, 32'h700, 12'h010, 1'b1, 1'b0);
    dec_br(2'b10, 32'h704, 12'h030, 1'b1, 1'b0);
    chk(mode_active && merge_pc == 32'h710 && pred_id == 5'd0, "R8 basic ignores",
        64'(merge_pc), 64'h710);
    policy_yield = 1'b1;
    dec_br(2'b10, 32'h708, 12'h040, 1'b1, 1'b1);
    chk(mode_active && merge_pc == 32'h710, "R8 path 1 ignored", 64'(merge_pc), 64'h710);
    fetch(32'h70C, 1'b0);
    push_exit(3'd4);
    push_entry(32'h74C, 5'd1);
    dec_br(2'b10, 32'h70C, 12'h040, 1'b1, 1'b0);
    chk(mode_active && sel_path == 1'b0, "R8 re-entered on path 0", 64'(sel_path), 64'd0);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    chk(!mode_active, "R9 flush idle", 64'(mode_active), 64'd0);
    push_entry(32'h810, 5'd1);
    dec_br(2'b10, 32'h800, 12'h010, 1'b1, 1'b0);
    chk(pred_id == 5'd1, "R9 flushed tag reused", 64'(pred_id), 64'd1);
    push_exit(3'd2);
    resolve();
    retire(5'd0);
    retire(5'd1);
    policy_yield = 1'b0;

    // R3 pool exhaustion
    for (int i = 0; i < 32; i++) begin
      push_entry(32'h1000 + 32'(i * 16) + 32'h8, IW'(i));
      dec_br(2'b10, 32'h1000 + 32'(i * 16), 12'h008, 1'b1, 1'b0);
      push_exit(3'd2);
      resolve();
    end
    dec_br(2'b10, 32'h2000, 12'h008, 1'b1, 1'b0);
    chk(!mode_active, "R3 no free tag", 64'(mode_active), 64'd0);
    retire(5'd5);
    push_entry(32'h2108, 5'd5);
    dec_br(2'b10, 32'h2100, 12'h008, 1'b1, 1'b0);
    chk(mode_active && pred_id == 5'd5, "R3 returned tag", 64'(pred_id), 64'd5);
    push_exit(3'd2);
    resolve();

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R1 scoreboard drained", 64'(q.size()), 64'd0);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule